// File: doc/BRIEF.md
# Interrupt Controller Read and Poll Path

This block decides what a priority interrupt controller places on its data bus when the processor reads it. A read at address 1 always presents the mask register. A read at address 0 presents one of two status registers, the request register or the in-service register. Which of the two it presents is set by a read-control command written earlier, and the choice persists until changed. A read-control command can also arm a poll. The next read, at either address, then becomes an acknowledge cycle. It returns a poll word in place of any register and sends a one-cycle acknowledge pulse to the priority logic when it completes.

The data outputs are enabled only while a chip-selected read strobe is active. When the controller sits behind external bus buffers (buffered mode), a buffer-enable output follows that output enable exactly. The neighbouring decoder supplies a flag that marks a written byte as a read-control command. The register values come from the rest of the controller. Priority resolution and the initialization sequence lie outside this block. Only the `init_pulse` input, which marks the end of initialization, reaches into it.

Top module: `irq_rdpath`

## Requirements
- R1: After reset or an `init_pulse`, an address-0 read returns the request register, and no poll is armed.
- R2: A read with `addr_bit`=1 and no poll armed returns the mask register, with no command needed first.
- R3: A read-control write (`sel`=1, `wr_stb`=1, `addr_bit`=0, `cmd_is_rdctl`=1, `cmd_poll`=0) with `cmd_rd_en`=1 selects the request register when `cmd_rd_svc`=0 and the in-service register when `cmd_rd_svc`=1. With `cmd_rd_en`=0 the current selection is kept.
- R4: A read-control write with `cmd_poll`=1 arms a poll. The next read, at either address, returns the poll word instead of a register.
- R5: The poll word has bit 7 set when any level in `req_reg & ~imr_reg` is pending. Bits 2:0 then hold the index of the lowest-numbered pending level, which has the highest priority. All other bits are 0, and the word is all zero when nothing is pending.
- R6: When `cmd_poll` and `cmd_rd_en` are both set in one command, the poll wins and the status selection is left unchanged.
- R7: A poll covers one read only. In the cycle after the clock edge that first sees the read strobe gone, `poll_ack` is high for exactly one cycle and the poll is disarmed. Later address-0 reads return the previously selected register.
- R8: `dout_oe` is high exactly while `sel` and `rd_stb` are both high, and `dout` is zero while it is low.
- R9: `buf_en` equals `dout_oe` when `buffered_mode`=1 and stays low when `buffered_mode`=0.
- R10: Writes with `sel`=0, `addr_bit`=1 or `cmd_is_rdctl`=0 change neither the selection nor the poll state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_pulse | input | 1 | Marks end of initialization; restores defaults |
| sel | input | 1 | Chip select, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| addr_bit | input | 1 | Address line |
| cmd_is_rdctl | input | 1 | Written byte is a read-control command |
| cmd_poll | input | 1 | Command field: arm poll |
| cmd_rd_en | input | 1 | Command field: update status selection |
| cmd_rd_svc | input | 1 | Command field: 1 = in-service, 0 = request |
| buffered_mode | input | 1 | External bus buffers in use |
| req_reg | input | 8 | Request register value |
| isr_reg | input | 8 | In-service register value |
| imr_reg | input | 8 | Mask register value |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Data output enable |
| buf_en | output | 1 | Bus buffer enable |
| poll_ack | output | 1 | One-cycle acknowledge pulse after a poll read |

## Verification
A wrong stored status selection shows on the very next address-0 read: the bus carries the other status register. A stuck or lost poll flag shows in the same way. Either a register appears where the poll word was expected, or the poll word appears on a read that should be plain. A missing or doubled `poll_ack` shows within two cycles of the read ending. Random register contents are chosen so that the request, in-service and mask values differ, which lets a wrong mux choice be told apart from a right one.

// File: rtl/irq_rd_pkg.sv
package irq_rd_pkg;

    typedef enum logic {
        STAT_REQ = 1'b0,
        STAT_SVC = 1'b1
    } stat_sel_e;

    typedef struct packed {
        logic poll;
        logic rd_en;
        logic rd_svc;
    } rdcmd_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_STAT = 2'd1,
        SRC_MASK = 2'd2,
        SRC_POLL = 2'd3
    } out_src_e;

    function automatic stat_sel_e decode_sel(input logic svc_bit);
        return svc_bit ? STAT_SVC : STAT_REQ;
    endfunction

endpackage

// File: rtl/irq_rd_ctl.sv
module irq_rd_ctl
    import irq_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_pulse,
    input  logic      sel,
    input  logic      rd_stb,
    input  logic      wr_stb,
    input  logic      addr_bit,
    input  logic      cmd_is_rdctl,
    input  rdcmd_t    cmd,
    output stat_sel_e stat_sel,
    output logic      poll_armed,
    output logic      rd_act,
    output logic      poll_ack
);

    logic rd_act_q;
    logic cmd_wr;
    logic rd_end;

    assign rd_act = sel & rd_stb;
    assign cmd_wr = sel & wr_stb & ~addr_bit & cmd_is_rdctl;
    assign rd_end = rd_act_q & ~rd_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q   <= 1'b0;
            poll_ack   <= 1'b0;
            poll_armed <= 1'b0;
            stat_sel   <= STAT_REQ;
        end else begin
            rd_act_q <= rd_act;
            poll_ack <= rd_end & poll_armed;
            if (init_pulse) begin
                poll_armed <= 1'b0;
                stat_sel   <= STAT_REQ;
            end else begin
                if (rd_end) begin
                    poll_armed <= 1'b0;
                end
                if (cmd_wr) begin
                    if (cmd.poll) begin
                        poll_armed <= 1'b1;
                    end else if (cmd.rd_en) begin
                        stat_sel <= decode_sel(cmd.rd_svc);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_poll_enc.sv
module irq_poll_enc #(
    parameter int NLVL = 8,
    parameter int DW   = 8
) (
    input  logic [NLVL-1:0] req,
    input  logic [NLVL-1:0] mask,
    output logic [DW-1:0]   poll_word
);

    localparam int IDXW = (NLVL > 1) ? $clog2(NLVL) : 1;

    logic [NLVL-1:0] pend;
    logic [NLVL-1:0] first;
    logic [NLVL:0]   seen;
    logic [IDXW-1:0] idx;

    assign pend    = req & ~mask;
    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < NLVL; gi++) begin : g_chain
        assign first[gi]  = pend[gi] & ~seen[gi];
        assign seen[gi+1] = seen[gi] | pend[gi];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (first[i]) begin
                idx = idx | IDXW'(i);
            end
        end
    end

    always_comb begin
        poll_word = '0;
        poll_word[DW-1] = seen[NLVL];
        poll_word[IDXW-1:0] = idx;
    end

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_rd_pkg::*;
#(
    parameter int NLVL = 8,
    parameter int DW   = 8
) (
    input  logic            rd_act,
    input  logic            addr_bit,
    input  logic            poll_armed,
    input  stat_sel_e       stat_sel,
    input  logic            buffered_mode,
    input  logic [NLVL-1:0] req_reg,
    input  logic [NLVL-1:0] isr_reg,
    input  logic [NLVL-1:0] imr_reg,
    input  logic [DW-1:0]   poll_word,
    output logic [DW-1:0]   dout,
    output logic            dout_oe,
    output logic            buf_en
);

    out_src_e src;

    always_comb begin
        if (!rd_act)          src = SRC_NONE;
        else if (poll_armed)  src = SRC_POLL;
        else if (addr_bit)    src = SRC_MASK;
        else                  src = SRC_STAT;
    end

    always_comb begin
        unique case (src)
            SRC_POLL: dout = poll_word;
            SRC_MASK: dout = DW'(imr_reg);
            SRC_STAT: dout = (stat_sel == STAT_SVC) ? DW'(isr_reg) : DW'(req_reg);
            default:  dout = '0;
        endcase
    end

    assign dout_oe = (src != SRC_NONE);
    assign buf_en  = dout_oe & buffered_mode;

endmodule

// File: rtl/irq_rdpath.sv
module irq_rdpath
    import irq_rd_pkg::*;
#(
    parameter int NLVL = 8,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            init_pulse,
    input  logic            sel,
    input  logic            rd_stb,
    input  logic            wr_stb,
    input  logic            addr_bit,
    input  logic            cmd_is_rdctl,
    input  logic            cmd_poll,
    input  logic            cmd_rd_en,
    input  logic            cmd_rd_svc,
    input  logic            buffered_mode,
    input  logic [NLVL-1:0] req_reg,
    input  logic [NLVL-1:0] isr_reg,
    input  logic [NLVL-1:0] imr_reg,
    output logic [DW-1:0]   dout,
    output logic            dout_oe,
    output logic            buf_en,
    output logic            poll_ack
);

    rdcmd_t          cmd;
    stat_sel_e       stat_sel;
    logic            poll_armed;
    logic            rd_act;
    logic [DW-1:0]   poll_word;

    assign cmd = '{poll: cmd_poll, rd_en: cmd_rd_en, rd_svc: cmd_rd_svc};

    irq_rd_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .init_pulse   (init_pulse),
        .sel          (sel),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .addr_bit     (addr_bit),
        .cmd_is_rdctl (cmd_is_rdctl),
        .cmd          (cmd),
        .stat_sel     (stat_sel),
        .poll_armed   (poll_armed),
        .rd_act       (rd_act),
        .poll_ack     (poll_ack)
    );

    irq_poll_enc #(.NLVL(NLVL), .DW(DW)) u_enc (
        .req       (req_reg),
        .mask      (imr_reg),
        .poll_word (poll_word)
    );

    irq_rd_mux #(.NLVL(NLVL), .DW(DW)) u_mux (
        .rd_act        (rd_act),
        .addr_bit      (addr_bit),
        .poll_armed    (poll_armed),
        .stat_sel      (stat_sel),
        .buffered_mode (buffered_mode),
        .req_reg       (req_reg),
        .isr_reg       (isr_reg),
        .imr_reg       (imr_reg),
        .poll_word     (poll_word),
        .dout          (dout),
        .dout_oe       (dout_oe),
        .buf_en        (buf_en)
    );

endmodule

// File: rtl/irq_rdpath_chk.sv
module irq_rdpath_chk #(
    parameter int NLVL = 8,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            sel,
    input logic            rd_stb,
    input logic            addr_bit,
    input logic            buffered_mode,
    input logic [NLVL-1:0] req_reg,
    input logic [NLVL-1:0] imr_reg,
    input logic [DW-1:0]   dout,
    input logic            dout_oe,
    input logic            buf_en,
    input logic            poll_ack,
    input logic            poll_armed
);

    p_oe_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        dout_oe == (sel && rd_stb));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> dout == '0);

    p_buf_mirror_r9: assert property (@(posedge clk) disable iff (rst)
        buf_en == (buffered_mode && sel && rd_stb));

    p_mask_read_r2: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_stb && addr_bit && !poll_armed) |-> dout == DW'(imr_reg));

    p_poll_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && poll_armed) |-> dout[DW-1] == (|(req_reg & ~imr_reg)));

    p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
        poll_ack |=> !poll_ack);

    p_ack_cause_r7: assert property (@(posedge clk) disable iff (rst)
        poll_ack |-> !poll_armed);

endmodule

bind irq_rdpath irq_rdpath_chk #(.NLVL(NLVL), .DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sel           (sel),
    .rd_stb        (rd_stb),
    .addr_bit      (addr_bit),
    .buffered_mode (buffered_mode),
    .req_reg       (req_reg),
    .imr_reg       (imr_reg),
    .dout          (dout),
    .dout_oe       (dout_oe),
    .buf_en        (buf_en),
    .poll_ack      (poll_ack),
    .poll_armed    (poll_armed)
);

// File: tb/irq_rdpath_test.sv
module irq_rdpath_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_pulse = 1'b0;
    logic       sel = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic       addr_bit = 1'b0;
    logic       cmd_is_rdctl = 1'b0;
    logic       cmd_poll = 1'b0;
    logic       cmd_rd_en = 1'b0;
    logic       cmd_rd_svc = 1'b0;
    logic       buffered_mode = 1'b0;
    logic [7:0] req_reg = 8'h00;
    logic [7:0] isr_reg = 8'h00;
    logic [7:0] imr_reg = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic       buf_en;
    logic       poll_ack;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;
    bit  m_svc = 1'b0;
    bit  m_poll = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_rdpath uut (
        .clk(clk), .rst(rst), .init_pulse(init_pulse), .sel(sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .addr_bit(addr_bit),
        .cmd_is_rdctl(cmd_is_rdctl), .cmd_poll(cmd_poll),
        .cmd_rd_en(cmd_rd_en), .cmd_rd_svc(cmd_rd_svc),
        .buffered_mode(buffered_mode), .req_reg(req_reg),
        .isr_reg(isr_reg), .imr_reg(imr_reg), .dout(dout),
        .dout_oe(dout_oe), .buf_en(buf_en), .poll_ack(poll_ack)
    );

    function automatic logic [7:0] exp_poll(input logic [7:0] r, input logic [7:0] m);
        logic [7:0] p;
        p = r & ~m;
        for (int i = 0; i < 8; i++) begin
            if (p[i]) return 8'h80 | 8'(i);
        end
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input bit p, input bit r, input bit s,
                          input bit cs, input bit a, input bit ctl);
        @(negedge clk);
        sel = cs; wr_stb = 1'b1; addr_bit = a; cmd_is_rdctl = ctl;
        cmd_poll = p; cmd_rd_en = r; cmd_rd_svc = s;
        @(negedge clk);
        sel = 1'b0; wr_stb = 1'b0; addr_bit = 1'b0; cmd_is_rdctl = 1'b0;
        cmd_poll = 1'b0; cmd_rd_en = 1'b0; cmd_rd_svc = 1'b0;
        if (cs && !a && ctl) begin
            if (p) m_poll = 1'b1;
            else if (r) m_svc = s;
        end
    endtask

    task automatic do_read(input bit a, input string tag);
        logic [7:0] e;
        bit was_poll;
        @(negedge clk);
        sel = 1'b1; rd_stb = 1'b1; addr_bit = a;
        #1;
        was_poll = m_poll;
        if (m_poll)      e = exp_poll(req_reg, imr_reg);
        else if (a)      e = imr_reg;
        else if (m_svc)  e = isr_reg;
        else             e = req_reg;
        chk(tag, dout, e);
        chk({tag, " R8 oe during read"}, 8'(dout_oe), 8'd1);
        chk({tag, " R9 buf_en"}, 8'(buf_en), 8'(buffered_mode));
        @(negedge clk);
        sel = 1'b0; rd_stb = 1'b0; addr_bit = 1'b0;
        #1;
        chk({tag, " R8 oe idle"}, 8'(dout_oe), 8'd0);
        chk({tag, " R8 dout idle"}, dout, 8'h00);
        @(negedge clk);
        #1;
        chk({tag, " R7 poll_ack"}, 8'(poll_ack), 8'(was_poll));
        m_poll = 1'b0;
        @(negedge clk);
        #1;
        chk({tag, " R7 ack single"}, 8'(poll_ack), 8'd0);
    endtask

    task automatic set_regs(input logic [7:0] r, input logic [7:0] s, input logic [7:0] m);
        @(negedge clk);
        req_reg = r; isr_reg = s; imr_reg = m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset default
        set_regs(8'h3c, 8'hc3, 8'h5a);
        #1;
        chk("R1 oe at reset", 8'(dout_oe), 8'd0);
        chk("R1 ack at reset", 8'(poll_ack), 8'd0);
        do_read(1'b0, "R1 default request");
        // R2: mask read without command
        do_read(1'b1, "R2 mask read");
        // R3: select in-service, keep, back to request
        do_cmd(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        do_read(1'b0, "R3 select svc");
        do_cmd(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        do_read(1'b0, "R3 keep svc");
        do_cmd(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        do_read(1'b0, "R3 select req");
        // R10: ignored writes
        do_cmd(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        do_read(1'b0, "R10 no sel");
        do_cmd(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        do_read(1'b0, "R10 addr1");
        do_cmd(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        do_read(1'b0, "R10 not rdctl");
        // R4 R5: poll with pending level 2 (level 1 masked)
        do_cmd(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        set_regs(8'b0100_0110, 8'h11, 8'b0000_0010);
        do_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R4 armed no oe", 8'(dout_oe), 8'd0);
        do_read(1'b0, "R4 R5 poll word");
        do_read(1'b0, "R7 back to svc");
        // R5: nothing pending, poll on address 1
        set_regs(8'h0f, 8'h22, 8'h0f);
        do_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        do_read(1'b1, "R5 poll empty addr1");
        do_read(1'b1, "R7 mask after poll");
        // R5: only level 7
        set_regs(8'h80, 8'h00, 8'h00);
        do_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        do_read(1'b0, "R5 level7");
        // R6: poll and select together, selection (svc) kept
        set_regs(8'h21, 8'h84, 8'h01);
        do_cmd(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        do_read(1'b0, "R6 poll wins");
        do_read(1'b0, "R6 selection kept");
        // R9: buffered mode
        buffered_mode = 1'b1;
        do_read(1'b1, "R9 buffered read");
        buffered_mode = 1'b0;
        // R1: init pulse restores default
        do_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        init_pulse = 1'b1;
        @(negedge clk);
        init_pulse = 1'b0;
        m_svc = 1'b0; m_poll = 1'b0;
        do_read(1'b0, "R1 after init");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            buffered_mode = 1'($urandom_range(0, 1));
            set_regs(8'($urandom), 8'($urandom), 8'($urandom));
            if (op < 2) begin
                do_cmd(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0),
                       ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) != 0));
            end else begin
                do_read(1'($urandom_range(0, 1)), "R3 R4 R10 random");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule